// File: doc/BRIEF.md
# Configurable subgraph compute array

This block executes a small dataflow graph of integer operations in a single invocation, in place of a short run of ordinary instructions. It takes four 32-bit operands and one configuration word per invocation and returns up to two 32-bit results. The configuration word gives every function unit its operation and the source of each of its operands. It also gives every output its source unit and an enable bit.

The function units sit in four rows. Rows 0 and 2 hold four full arithmetic/logic units each. Rows 1 and 3 hold two cheaper units each, and those units do bitwise logic only. Between adjacent rows a crossbar lets any unit read any result of the row above, any array input, or a small signed immediate. Output selectors may pick any unit in any row.

The whole graph is combinational. It is followed by a configurable number of register stages, so results appear 1 to 4 cycles after the valid input, and a new invocation can be accepted on every cycle. Illegal codes produce a zero result and raise a fault flag, which travels with the results.

Top module: `subg_array`

## Requirements
- R1: `vld_o` equals `vld_i` delayed by exactly `LAT` cycles (parameter, 1..4), and the results and the fault flag of an invocation appear together with that delayed valid; one invocation may be issued on every cycle.
- R2: Units are numbered globally row by row. Row 0 holds units 0-3, row 1 holds units 4-5, row 2 holds units 6-9 and row 3 holds units 10-11. `cfg_i` is the packed struct `array_cfg_t`, whose field `units[i]` configures unit i.
- R3: An operand selector code c works as follows:
  - c in 0..3 picks `in_a`, `in_b`, `in_c` or `in_d` in that order.
  - c = 15 picks the unit's 8-bit immediate, sign-extended.
  - c in 4..14 picks result c-4 of the previous row, counting within that row.
  - Any other code is a fault: this covers every code 4..14 in row 0 and any code beyond the width of the previous row. A fault forces the unit result to zero.
- R4: Arithmetic/logic units take the opcodes 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR, 6 NOT A, 7 A<<B[4:0], 8 logical A>>B[4:0], 9 arithmetic A>>B[4:0], 10 sign-extend byte of A, and 11 sign-extend halfword of A. Opcodes 12-15 are a fault and give a zero result.
- R5: Logic-only units (rows 1 and 3) take only the opcodes 0, 3, 4, 5 and 6. Any other opcode is a fault and gives a zero result.
- R6: Output k (`res0_o`, `res1_o`) is set by `outs[k]`, which holds `en` and a 4-bit `sel`. When `en` is 0 the output is zero and is never a fault. When `en` is 1 and `sel` is 0..11, the output is the result of unit `sel`. When `en` is 1 and `sel` is 12..15, the output is zero and the case is a fault.
- R7: `err_o` is the OR of all unit faults and all enabled output faults of an invocation, and it is only ever high while `vld_o` is high.
- R8: A synchronous active-high `rst` clears every pipeline valid bit, so `vld_o` is low on the cycle after `rst` is sampled high.
- R9: The array computes `(in_a AND -4) OR (sign_extend_byte(in_b) AND 3)` as one invocation, with one output enabled and the other output zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Invocation valid |
| in_a | input | 32 | Array input 0 |
| in_b | input | 32 | Array input 1 |
| in_c | input | 32 | Array input 2 |
| in_d | input | 32 | Array input 3 |
| cfg_i | input | CFG_W (250) | Packed `array_cfg_t` configuration |
| vld_o | output | 1 | Result valid, LAT cycles after `vld_i` |
| res0_o | output | 32 | Output 0 |
| res1_o | output | 32 | Output 1 |
| err_o | output | 1 | Fault flag for the invocation |

## Verification
The hardest case to reach is a value that crosses all four rows through the crossbar while every selector along the path stays legal. Uniformly random codes almost always hit a fault in some unit early on. The stimulus therefore draws most selector codes from the legal set for each row, and it reserves a small fraction for illegal codes. Directed cases add a pass chain from an input down to the last logic row, the sample mask-and-merge graph, and each kind of fault in isolation, while back-to-back invocations exercise a new configuration on every cycle.

// File: rtl/subg_pkg.sv
package subg_pkg;
  localparam int DATA_W  = 32;
  localparam int NIN     = 4;
  localparam int NROWS   = 4;
  localparam int MAXU    = 4;
  localparam int NU      = 12;
  localparam int NOUT    = 2;
  localparam int SEL_W   = 4;
  localparam int OP_W    = 4;
  localparam int IMM_W   = 8;
  localparam int OSEL_W  = 4;
  localparam int IN_IDX_W = $clog2(NIN);
  localparam int U_IDX_W  = $clog2(MAXU);
  localparam int SH_W     = $clog2(DATA_W);
  localparam logic [SEL_W-1:0] SEL_IMM = '1;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
    OP_OR   = 4'd4, OP_XOR = 4'd5, OP_NOT = 4'd6, OP_SHL = 4'd7,
    OP_SHR  = 4'd8, OP_SRA = 4'd9, OP_SXB = 4'd10, OP_SXH = 4'd11
  } fu_op_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [IMM_W-1:0] imm;
  } unit_cfg_t;

  typedef struct packed {
    logic              en;
    logic [OSEL_W-1:0] sel;
  } out_cfg_t;

  typedef struct packed {
    out_cfg_t  [NOUT-1:0] outs;
    unit_cfg_t [NU-1:0]   units;
  } array_cfg_t;

  localparam int CFG_W = $bits(array_cfg_t);

  function automatic int row_units(int r);
    return (r % 2 == 0) ? 4 : 2;
  endfunction

  function automatic int row_base(int r);
    int b;
    b = 0;
    for (int k = 0; k < r; k++) b += row_units(k);
    return b;
  endfunction

  function automatic bit row_is_alu(int r);
    return (r % 2 == 0);
  endfunction

  // Evaluates one unit; flt reports an opcode the unit kind lacks.
  function automatic logic [DATA_W-1:0] fu_eval(
      input logic [OP_W-1:0] op, input logic [DATA_W-1:0] a,
      input logic [DATA_W-1:0] b, input bit alu, output logic flt);
    logic [DATA_W-1:0] r;
    logic [SH_W-1:0]   sh;
    sh  = b[SH_W-1:0];
    r   = '0;
    flt = 1'b0;
    case (op)
      OP_PASS: r = a;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NOT:  r = ~a;
      OP_ADD:  if (alu) r = a + b; else flt = 1'b1;
      OP_SUB:  if (alu) r = a - b; else flt = 1'b1;
      OP_SHL:  if (alu) r = a << sh; else flt = 1'b1;
      OP_SHR:  if (alu) r = a >> sh; else flt = 1'b1;
      OP_SRA:  if (alu) r = $unsigned($signed(a) >>> sh); else flt = 1'b1;
      OP_SXB:  if (alu) r = {{(DATA_W-8){a[7]}}, a[7:0]}; else flt = 1'b1;
      OP_SXH:  if (alu) r = {{(DATA_W-16){a[15]}}, a[15:0]}; else flt = 1'b1;
      default: flt = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/subg_opnd_mux.sv
module subg_opnd_mux
  import subg_pkg::*;
#(
  parameter int PREV_N = 4
) (
  input  logic [SEL_W-1:0]              sel,
  input  logic [IMM_W-1:0]              imm,
  input  logic [NIN-1:0][DATA_W-1:0]    ins,
  input  logic [MAXU-1:0][DATA_W-1:0]   prev,
  output logic [DATA_W-1:0]             val,
  output logic                          bad
);
  always_comb begin
    logic [SEL_W-1:0] k;
    k   = sel - SEL_W'(NIN);
    val = '0;
    bad = 1'b0;
    if (sel < SEL_W'(NIN)) begin
      val = ins[sel[IN_IDX_W-1:0]];
    end else if (sel == SEL_IMM) begin
      val = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else if (k < SEL_W'(PREV_N)) begin
      val = prev[k[U_IDX_W-1:0]];
    end else begin
      bad = 1'b1;
    end
  end
endmodule

// File: rtl/subg_fu.sv
module subg_fu
  import subg_pkg::*;
#(
  parameter int PREV_N = 4,
  parameter bit IS_ALU = 1'b1
) (
  input  unit_cfg_t                     cfg,
  input  logic [NIN-1:0][DATA_W-1:0]    ins,
  input  logic [MAXU-1:0][DATA_W-1:0]   prev,
  output logic [DATA_W-1:0]             y,
  output logic                          err
);
  logic [DATA_W-1:0] opa, opb, raw;
  logic bad_a, bad_b, bad_op;

  subg_opnd_mux #(.PREV_N(PREV_N)) i_mux_a (
    .sel(cfg.sel_a), .imm(cfg.imm), .ins(ins), .prev(prev), .val(opa), .bad(bad_a));
  subg_opnd_mux #(.PREV_N(PREV_N)) i_mux_b (
    .sel(cfg.sel_b), .imm(cfg.imm), .ins(ins), .prev(prev), .val(opb), .bad(bad_b));

  always_comb begin
    raw = fu_eval(cfg.op, opa, opb, IS_ALU, bad_op);
    err = bad_a | bad_b | bad_op;
    y   = err ? '0 : raw;
  end
endmodule

// File: rtl/subg_pipe.sv
module subg_pipe #(
  parameter int LAT = 1,
  parameter int PW  = 65
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [PW-1:0] d_i,
  output logic          vld_o,
  output logic [PW-1:0] d_o
);
  logic [LAT:0]         v;
  logic [LAT:0][PW-1:0] d;
  logic                 hist_ok;

  assign v[0] = vld_i;
  assign d[0] = d_i;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) v[s+1] <= 1'b0;
      else     v[s+1] <= v[s];
      d[s+1] <= d[s];
    end
    AST_VALID_STEP: assert property (@(posedge clk) disable iff (rst || !hist_ok)
      v[s+1] == $past(v[s])); // R1
  end

  always_ff @(posedge clk) hist_ok <= !rst;

  assign vld_o = v[LAT];
  assign d_o   = d[LAT];
endmodule

// File: rtl/subg_array.sv
module subg_array
  import subg_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  input  logic [DATA_W-1:0] in_d,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res0_o,
  output logic [DATA_W-1:0] res1_o,
  output logic              err_o
);
  localparam int PW = NOUT*DATA_W + 1;

  array_cfg_t                              cfg;
  logic [NIN-1:0][DATA_W-1:0]              ins;
  logic [NROWS-1:0][MAXU-1:0][DATA_W-1:0]  rbus;
  logic [NROWS-1:0][MAXU-1:0]              ebus;
  logic [NU-1:0][DATA_W-1:0]               all_res;
  logic [NU-1:0]                           all_err;
  logic [NOUT-1:0][DATA_W-1:0]             out_val;
  logic [NOUT-1:0]                         out_bad;
  logic                                    fault;
  logic [PW-1:0]                           pipe_d;
  logic                                    pipe_err;

  assign cfg = array_cfg_t'(cfg_i);
  assign ins = {in_d, in_c, in_b, in_a};

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    localparam int NUR  = row_units(r);
    localparam int BASE = row_base(r);
    localparam int PN   = (r == 0) ? 0 : row_units(r - 1);
    logic [MAXU-1:0][DATA_W-1:0] pv;
    if (r == 0) begin : g_first
      assign pv = '0;
    end else begin : g_next
      assign pv = rbus[r-1];
    end
    for (genvar u = 0; u < MAXU; u++) begin : g_unit
      if (u < NUR) begin : g_fu
        subg_fu #(.PREV_N(PN), .IS_ALU(row_is_alu(r))) i_fu (
          .cfg(cfg.units[BASE+u]), .ins(ins), .prev(pv),
          .y(rbus[r][u]), .err(ebus[r][u]));
        assign all_res[BASE+u] = rbus[r][u];
        assign all_err[BASE+u] = ebus[r][u];
        AST_UNIT_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
          ebus[r][u] |-> rbus[r][u] == '0); // R5
      end else begin : g_empty
        assign rbus[r][u] = '0;
        assign ebus[r][u] = 1'b0;
      end
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    always_comb begin
      out_val[o] = '0;
      out_bad[o] = 1'b0;
      if (cfg.outs[o].en) begin
        if (cfg.outs[o].sel < OSEL_W'(NU)) out_val[o] = all_res[cfg.outs[o].sel];
        else                               out_bad[o] = 1'b1;
      end
    end
    AST_OUT_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
      !cfg.outs[o].en |-> (out_val[o] == '0 && !out_bad[o])); // R6
  end

  assign fault  = (|all_err) | (|out_bad);
  assign pipe_d = {fault, out_val[1], out_val[0]};

  subg_pipe #(.LAT(LAT), .PW(PW)) i_pipe (
    .clk(clk), .rst(rst), .vld_i(vld_i), .d_i(pipe_d), .vld_o(vld_o), .d_o(pipe_d_o));

  logic [PW-1:0] pipe_d_o;
  assign pipe_err = pipe_d_o[PW-1];
  assign res0_o   = pipe_d_o[DATA_W-1:0];
  assign res1_o   = pipe_d_o[2*DATA_W-1:DATA_W];
  assign err_o    = vld_o & pipe_err;

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    err_o |-> vld_o); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !vld_o); // R8
endmodule

// File: tb/test_subg_array.sv
module test_subg_array;
  import subg_pkg::*;
  localparam int LAT = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld_i = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  array_cfg_t cfg = '0;
  logic vld_o, err_o;
  logic [31:0] res0_o, res1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          q_v[$];
  logic [31:0] q_r0[$];
  logic [31:0] q_r1[$];
  bit          q_e[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  subg_array #(.LAT(LAT)) i_subg_array (
    .clk(clk), .rst(rst), .vld_i(vld_i), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .in_d(in_d), .cfg_i(cfg), .vld_o(vld_o), .res0_o(res0_o), .res1_o(res1_o), .err_o(err_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent reference of one unit position: row, previous row base/width
  function automatic int t_row(int u);
    return (u < 4) ? 0 : (u < 6) ? 1 : (u < 10) ? 2 : 3;
  endfunction

  function automatic void ref_model(array_cfg_t c, logic [31:0] a0, logic [31:0] a1,
      logic [31:0] a2, logic [31:0] a3, output logic [31:0] o0, output logic [31:0] o1,
      output bit e);
    logic [31:0] res [12];
    logic [31:0] srcv [2];
    logic [31:0] x, y;
    int row, pb, pn, code, k;
    bit f;
    e = 0;
    for (int u = 0; u < 12; u++) begin
      row = t_row(u);
      pb = (row == 1) ? 0 : (row == 2) ? 4 : 6;
      pn = (row == 0) ? 0 : (row == 2) ? 2 : 4;
      f = 0;
      for (int s = 0; s < 2; s++) begin
        code = (s == 0) ? int'(c.units[u].sel_a) : int'(c.units[u].sel_b);
        srcv[s] = 32'h0;
        if (code == 0) srcv[s] = a0;
        else if (code == 1) srcv[s] = a1;
        else if (code == 2) srcv[s] = a2;
        else if (code == 3) srcv[s] = a3;
        else if (code == 15) srcv[s] = {{24{c.units[u].imm[7]}}, c.units[u].imm};
        else begin
          k = code - 4;
          if (k < pn) srcv[s] = res[pb + k]; else f = 1;
        end
      end
      x = srcv[0]; y = srcv[1];
      res[u] = 32'h0;
      case (int'(c.units[u].op))
        0: res[u] = x;
        3: res[u] = x & y;
        4: res[u] = x | y;
        5: res[u] = x ^ y;
        6: res[u] = ~x;
        1: if (row % 2 == 0) res[u] = x + y; else f = 1;
        2: if (row % 2 == 0) res[u] = x - y; else f = 1;
        7: if (row % 2 == 0) res[u] = x << y[4:0]; else f = 1;
        8: if (row % 2 == 0) res[u] = x >> y[4:0]; else f = 1;
        9: if (row % 2 == 0) res[u] = 32'($signed(x) >>> y[4:0]); else f = 1;
        10: if (row % 2 == 0) res[u] = {{24{x[7]}}, x[7:0]}; else f = 1;
        11: if (row % 2 == 0) res[u] = {{16{x[15]}}, x[15:0]}; else f = 1;
        default: f = 1;
      endcase
      if (f) begin res[u] = 32'h0; e = 1; end
    end
    o0 = 0; o1 = 0;
    if (c.outs[0].en) begin
      if (c.outs[0].sel < 12) o0 = res[c.outs[0].sel]; else e = 1;
    end
    if (c.outs[1].en) begin
      if (c.outs[1].sel < 12) o1 = res[c.outs[1].sel]; else e = 1;
    end
  endfunction

  task automatic pop_check();
    bit v, e;
    logic [31:0] r0, r1;
    string t;
    if (q_v.size() < LAT) return;
    v = q_v.pop_front(); r0 = q_r0.pop_front(); r1 = q_r1.pop_front();
    e = q_e.pop_front(); t = q_tag.pop_front();
    chk({t, " R1 valid"}, {31'h0, vld_o}, {31'h0, v});
    if (v) begin
      chk({t, " res0"}, res0_o, r0);
      chk({t, " res1"}, res1_o, r1);
      chk({t, " R7 err"}, {31'h0, err_o}, {31'h0, e});
    end else begin
      chk({t, " R7 err idle"}, {31'h0, err_o}, 32'h0);
    end
  endtask

  task automatic issue_exp(bit v, array_cfg_t c, logic [31:0] a0, logic [31:0] a1,
      logic [31:0] a2, logic [31:0] a3, logic [31:0] e0, logic [31:0] e1, bit ee, string tag);
    @(negedge clk);
    pop_check();
    vld_i = v; cfg = c; in_a = a0; in_b = a1; in_c = a2; in_d = a3;
    q_v.push_back(v); q_r0.push_back(e0); q_r1.push_back(e1);
    q_e.push_back(ee); q_tag.push_back(tag);
  endtask

  task automatic issue(bit v, array_cfg_t c, logic [31:0] a0, logic [31:0] a1,
      logic [31:0] a2, logic [31:0] a3, string tag);
    logic [31:0] e0, e1;
    bit ee;
    ref_model(c, a0, a1, a2, a3, e0, e1, ee);
    issue_exp(v, c, a0, a1, a2, a3, e0, e1, ee, tag);
  endtask

  function automatic array_cfg_t base_cfg();
    array_cfg_t c;
    c = '0;
    return c;
  endfunction

  function automatic logic [3:0] legal_sel(int u);
    int row, pn, pick;
    row = t_row(u);
    pn = (row == 0) ? 0 : (row == 2) ? 2 : 4;
    pick = $urandom_range(0, 4 + pn);
    if (pick < 4) return 4'(pick);
    if (pick == 4) return 4'd15;
    return 4'(pick - 1);
  endfunction

  function automatic logic [31:0] rnd_word();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'h0000_0080;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_8000;
      default: return $urandom();
    endcase
  endfunction

  function automatic array_cfg_t rnd_cfg();
    array_cfg_t c;
    int row;
    c = '0;
    for (int u = 0; u < 12; u++) begin
      row = t_row(u);
      if ($urandom_range(0, 19) == 0) c.units[u].op = 4'($urandom_range(0, 15));
      else if (row % 2 == 0) c.units[u].op = 4'($urandom_range(0, 11));
      else begin
        case ($urandom_range(0, 4))
          0: c.units[u].op = 4'd0; 1: c.units[u].op = 4'd3; 2: c.units[u].op = 4'd4;
          3: c.units[u].op = 4'd5; default: c.units[u].op = 4'd6;
        endcase
      end
      c.units[u].sel_a = ($urandom_range(0, 29) == 0) ? 4'($urandom_range(0, 15)) : legal_sel(u);
      c.units[u].sel_b = ($urandom_range(0, 29) == 0) ? 4'($urandom_range(0, 15)) : legal_sel(u);
      c.units[u].imm   = 8'($urandom());
    end
    for (int o = 0; o < 2; o++) begin
      c.outs[o].en  = ($urandom_range(0, 4) != 0);
      c.outs[o].sel = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(12, 15))
                                                    : 4'($urandom_range(0, 11));
    end
    return c;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    array_cfg_t c;
    logic [31:0] a, b, ex;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {31'h0, vld_o}, 32'h0);
    chk("R7 reset err", {31'h0, err_o}, 32'h0);
    rst = 1'b0;

    // R9: mask-and-merge sample graph
    a = 32'h1234_5677; b = 32'h0000_00F6;
    c = base_cfg();
    c.units[0] = '{op: 4'd3, sel_a: 4'd0, sel_b: 4'd15, imm: 8'hFC};
    c.units[1] = '{op: 4'd10, sel_a: 4'd1, sel_b: 4'd0, imm: 8'h00};
    c.units[4] = '{op: 4'd0, sel_a: 4'd4, sel_b: 4'd0, imm: 8'h00};
    c.units[5] = '{op: 4'd3, sel_a: 4'd5, sel_b: 4'd15, imm: 8'h03};
    c.units[6] = '{op: 4'd4, sel_a: 4'd4, sel_b: 4'd5, imm: 8'h00};
    c.outs[0] = '{en: 1'b1, sel: 4'd6};
    ex = (a & 32'hFFFF_FFFC) | ({{24{b[7]}}, b[7:0]} & 32'h3);
    issue_exp(1, c, a, b, 0, 0, ex, 32'h0, 0, "R9 sample graph");

    // R2: pass chain from in_c through all rows to unit 11
    c = base_cfg();
    c.units[1]  = '{op: 4'd0, sel_a: 4'd2, sel_b: 4'd0, imm: 8'h00};
    c.units[5]  = '{op: 4'd0, sel_a: 4'd5, sel_b: 4'd0, imm: 8'h00};
    c.units[9]  = '{op: 4'd0, sel_a: 4'd5, sel_b: 4'd0, imm: 8'h00};
    c.units[11] = '{op: 4'd0, sel_a: 4'd7, sel_b: 4'd0, imm: 8'h00};
    c.outs[0] = '{en: 1'b1, sel: 4'd11};
    c.outs[1] = '{en: 1'b1, sel: 4'd9};
    issue_exp(1, c, 1, 2, 32'hCAFE_F00D, 4, 32'hCAFE_F00D, 32'hCAFE_F00D, 0, "R2 chain");

    // R4: arithmetic shift and halfword sign-extend
    c = base_cfg();
    c.units[0] = '{op: 4'd9, sel_a: 4'd0, sel_b: 4'd15, imm: 8'h04};
    c.units[1] = '{op: 4'd11, sel_a: 4'd1, sel_b: 4'd0, imm: 8'h00};
    c.outs[0] = '{en: 1'b1, sel: 4'd0};
    c.outs[1] = '{en: 1'b1, sel: 4'd1};
    issue_exp(1, c, 32'h8000_0000, 32'h0000_8001, 0, 0, 32'hF800_0000, 32'hFFFF_8001, 0,
              "R4 sra/sxh");

    // R3: immediate sign extension, then row 0 naming a previous row (fault)
    c = base_cfg();
    c.units[0] = '{op: 4'd0, sel_a: 4'd15, sel_b: 4'd0, imm: 8'h80};
    c.outs[0] = '{en: 1'b1, sel: 4'd0};
    issue_exp(1, c, 0, 0, 0, 0, 32'hFFFF_FF80, 32'h0, 0, "R3 imm");
    c.units[0].sel_a = 4'd4;
    issue_exp(1, c, 5, 0, 0, 0, 32'h0, 32'h0, 1, "R3 row0 prev fault");

    // R5: logic-only unit asked to add
    c = base_cfg();
    c.units[4] = '{op: 4'd1, sel_a: 4'd0, sel_b: 4'd1, imm: 8'h00};
    c.outs[0] = '{en: 1'b1, sel: 4'd4};
    issue_exp(1, c, 7, 9, 0, 0, 32'h0, 32'h0, 1, "R5 logic add fault");

    // R6: disabled output reads zero without fault; illegal select faults
    c = base_cfg();
    c.outs[0] = '{en: 1'b0, sel: 4'd14};
    c.outs[1] = '{en: 1'b0, sel: 4'd0};
    issue_exp(1, c, 32'h1111_1111, 0, 0, 0, 32'h0, 32'h0, 0, "R6 disabled");
    c.outs[1] = '{en: 1'b1, sel: 4'd13};
    issue_exp(1, c, 32'h1111_1111, 0, 0, 0, 32'h0, 32'h0, 1, "R6 bad select");

    // R1: idle gap then random back-to-back and gapped invocations
    issue(0, base_cfg(), 0, 0, 0, 0, "R1 idle");
    for (int n = 0; n < 400; n++) begin
      issue(($urandom_range(0, 4) != 0), rnd_cfg(), rnd_word(), rnd_word(), rnd_word(),
            rnd_word(), "R4 random");
    end

    // R8: reset in mid-stream drops in-flight work
    issue(1, rnd_cfg(), rnd_word(), rnd_word(), 1, 2, "R8 pre");
    @(negedge clk);
    rst = 1'b1; vld_i = 1'b0;
    q_v.delete(); q_r0.delete(); q_r1.delete(); q_e.delete(); q_tag.delete();
    @(negedge clk);
    chk("R8 mid reset valid", {31'h0, vld_o}, 32'h0);
    rst = 1'b0;
    repeat (LAT + 1) issue(0, base_cfg(), 0, 0, 0, 0, "R1 drain");
    @(negedge clk);
    pop_check();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule